// File: doc/BRIEF.md
# NAND Flash Page Array Emulator

This block acts as a small NAND flash device, meant to be the device under a host controller in a self-checking simulation. It decodes the host strobes into command, address, data-in and data-out phases. Each byte is latched on a rising write strobe while chip enable is low. It keeps a handful of pages in registers. Each page is split into a main area and a spare area.

Program, erase and read commands hold a busy output high for durations given in microseconds and scaled by a cycles-per-microsecond parameter. A second confirm code for program yields the short dummy busy used between plane phases. Programming can only clear bits. Each page counts how many times its main and spare areas have been programmed since the last erase, and the block refuses programs beyond that budget. A low write-protect input refuses program and erase. A status byte reports pass or fail for the last program or erase.

Top module: `nand_emu`

## Requirements
- R1: With `ce_n` low, a rising edge of `we_n` latches `din` as a command when `cle`=1 and `ale`=0, as an address byte when `cle`=0 and `ale`=1, and as a data byte when both are 0. With `ce_n` high, no strobe has any effect.
- R2: Commands use these codes: 0x00 read, 0x80 program setup, 0x10 program confirm, 0x11 plane confirm, 0x60 erase setup, 0xD0 erase confirm, 0x70 status, 0xFF reset. Every read, program and erase takes exactly four address bytes. Byte 0 is the column. Bytes 1 and 2 are the low and high row bytes, and the page index is taken from the low row bits. Byte 3 is ignored. A read starts only after the fourth byte.
- R3: Program confirm stores the old byte AND the new byte at every written column. Columns not written during the program keep their values.
- R4: The main area (columns 0 to PAGE_MAIN-1) of a page accepts one program between erases. A later program that writes the main area is rejected and leaves the page unchanged.
- R5: The spare area (columns PAGE_MAIN and up) of a page accepts two programs between erases. A third program that writes the spare area is rejected and leaves the page unchanged.
- R6: While `wp_n` is low, program and erase confirms are refused, the array is left unchanged, and the status is set to fail.
- R7: Erase sets every byte of the addressed block to 0xFF and clears the program counts of all of its pages. Other blocks keep their contents.
- R8: After a confirm, `busy` stays high for PROG_US*CYC_PER_US cycles for program (0x10), ERASE_US*CYC_PER_US cycles for erase, and DUMMY_US*CYC_PER_US cycles for plane confirm (0x11). After the fourth read address byte, it stays high for READ_US*CYC_PER_US cycles.
- R9: While `busy` is high, every strobe except the 0xFF command is ignored. The 0xFF command ends busy at once and returns the block to idle.
- R10: After command 0x70, the output byte is bit 7 = `wp_n`, bit 6 = ready (not busy), bit 0 = 1 if the last program or erase failed. All other bits are 0.
- R11: After reset, `busy` and `dout_en` are low and every array byte reads 0xFF.
- R12: In read output, `dout` shows the byte at the current column. Each rising edge of `re_n` advances the column by one. Columns past the page end read 0xFF. `dout_en` is high only when `ce_n` and `re_n` are low, `busy` is low, and the block is in read or status output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| cle | input | 1 | Command latch enable |
| ale | input | 1 | Address latch enable |
| we_n | input | 1 | Write strobe, latches on rising edge |
| re_n | input | 1 | Read strobe, advances column on rising edge |
| wp_n | input | 1 | Write protect, active low |
| din | input | 8 | Byte from host |
| dout | output | 8 | Byte to host |
| dout_en | output | 1 | Output byte valid |
| busy | output | 1 | Device busy |

## Verification
The assertions assume that the host strobes are synchronous to `clk` and that each level is held for at least one clock. Under that assumption, every strobe edge is seen exactly once by the edge detectors. They also assume that `re_n` is not pulsed during busy in a way that would have to show data. The bench changes all inputs only on falling clock edges and holds each strobe phase for a full cycle. It never lets `cle` and `ale` be high together.

// File: rtl/nand_emu_pkg.sv
package nand_emu_pkg;

  localparam logic [7:0] CMD_READ       = 8'h00;
  localparam logic [7:0] CMD_PROG       = 8'h80;
  localparam logic [7:0] CMD_PROG_GO    = 8'h10;
  localparam logic [7:0] CMD_PROG_PLANE = 8'h11;
  localparam logic [7:0] CMD_ERASE      = 8'h60;
  localparam logic [7:0] CMD_ERASE_GO   = 8'hD0;
  localparam logic [7:0] CMD_STATUS     = 8'h70;
  localparam logic [7:0] CMD_RESET      = 8'hFF;

  typedef enum logic [1:0] {
    BK_READ, BK_PROG, BK_DUMMY, BK_ERASE
  } busy_kind_e;

  typedef enum logic [2:0] {
    M_IDLE, M_RD_ADDR, M_RD_OUT, M_PG_ADDR, M_PG_DATA,
    M_ER_ADDR, M_ER_WAIT, M_STATUS
  } mode_e;

endpackage

// File: rtl/nand_bus_decode.sv
module nand_bus_decode (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n,
  input  logic cle,
  input  logic ale,
  input  logic we_n,
  input  logic re_n,
  output logic cmd_stb,
  output logic addr_stb,
  output logic data_stb,
  output logic rd_adv
);
  logic we_q, re_q;
  logic we_rise, re_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q <= 1'b1;
      re_q <= 1'b1;
    end else begin
      we_q <= we_n;
      re_q <= re_n;
    end
  end

  always_comb begin
    we_rise  = we_n & ~we_q & ~ce_n;
    re_rise  = re_n & ~re_q & ~ce_n;
    cmd_stb  = we_rise &  cle & ~ale;
    addr_stb = we_rise & ~cle &  ale;
    data_stb = we_rise & ~cle & ~ale;
    rd_adv   = re_rise;
  end
endmodule

// File: rtl/nand_busy_timer.sv
module nand_busy_timer
  import nand_emu_pkg::*;
#(
  parameter int CYC_PER_US = 1,
  parameter int READ_US    = 25,
  parameter int PROG_US    = 200,
  parameter int DUMMY_US   = 5,
  parameter int ERASE_US   = 2000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  busy_kind_e kind,
  input  logic       clear,
  output logic       busy
);
  localparam int READ_CYC  = READ_US  * CYC_PER_US;
  localparam int PROG_CYC  = PROG_US  * CYC_PER_US;
  localparam int DUMMY_CYC = DUMMY_US * CYC_PER_US;
  localparam int ERASE_CYC = ERASE_US * CYC_PER_US;
  localparam int CNT_W     = $clog2(ERASE_CYC + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d, load_val;

  always_comb begin
    unique case (kind)
      BK_READ:  load_val = CNT_W'(READ_CYC);
      BK_PROG:  load_val = CNT_W'(PROG_CYC);
      BK_DUMMY: load_val = CNT_W'(DUMMY_CYC);
      default:  load_val = CNT_W'(ERASE_CYC);
    endcase
    cnt_d = cnt_q;
    if (clear)               cnt_d = '0;
    else if (start)          cnt_d = load_val;
    else if (cnt_q != '0)    cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign busy = (cnt_q != '0);
endmodule

// File: rtl/nand_page_store.sv
module nand_page_store #(
  parameter int PAGE_MAIN  = 8,
  parameter int PAGE_SPARE = 2,
  parameter int PPB        = 2,
  parameter int BLOCKS     = 2,
  localparam int PAGES      = PPB * BLOCKS,
  localparam int PAGE_BYTES = PAGE_MAIN + PAGE_SPARE,
  localparam int PAGE_W     = $clog2(PAGES),
  localparam int COL_W      = $clog2(PAGE_BYTES),
  localparam int BLK_W      = $clog2(BLOCKS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [PAGE_W-1:0]           prog_page,
  input  logic [PAGE_BYTES-1:0][7:0]  prog_buf,
  input  logic                        prog_main,
  input  logic                        prog_spare,
  input  logic                        prog_en,
  output logic                        limit_ok,
  input  logic                        erase_en,
  input  logic [BLK_W-1:0]            erase_blk,
  input  logic [PAGE_W-1:0]           rd_page,
  input  logic [COL_W-1:0]            rd_col,
  output logic [7:0]                  rd_byte
);
  logic [PAGES-1:0][PAGE_BYTES-1:0][7:0] mem_q;
  logic [PAGES-1:0]                      main_cnt_q;
  logic [PAGES-1:0][1:0]                 spare_cnt_q;

  always_comb begin
    limit_ok = ~(prog_main & main_cnt_q[prog_page]) &
               ~(prog_spare & (spare_cnt_q[prog_page] == 2'd2));
    rd_byte  = mem_q[rd_page][rd_col];
  end

  for (genvar p = 0; p < PAGES; p++) begin : g_page
    localparam int BLK = p / PPB;
    logic hit_erase, hit_prog;
    logic [PAGE_BYTES-1:0][7:0] page_d;
    logic       main_d;
    logic [1:0] spare_d;

    always_comb begin
      hit_erase = erase_en & (erase_blk == BLK_W'(BLK));
      hit_prog  = prog_en  & (prog_page == PAGE_W'(p));
      page_d    = mem_q[p];
      main_d    = main_cnt_q[p];
      spare_d   = spare_cnt_q[p];
      if (hit_erase) begin
        page_d  = '1;
        main_d  = 1'b0;
        spare_d = 2'd0;
      end else if (hit_prog) begin
        page_d = mem_q[p] & prog_buf;
        if (prog_main)  main_d  = 1'b1;
        if (prog_spare) spare_d = spare_cnt_q[p] + 2'd1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mem_q[p]       <= '1;
        main_cnt_q[p]  <= 1'b0;
        spare_cnt_q[p] <= 2'd0;
      end else if (hit_erase | hit_prog) begin
        mem_q[p]       <= page_d;
        main_cnt_q[p]  <= main_d;
        spare_cnt_q[p] <= spare_d;
      end
    end
  end
endmodule

// File: rtl/nand_emu.sv
module nand_emu
  import nand_emu_pkg::*;
#(
  parameter int PAGE_MAIN  = 8,
  parameter int PAGE_SPARE = 2,
  parameter int PPB        = 2,
  parameter int BLOCKS     = 2,
  parameter int CYC_PER_US = 1,
  parameter int READ_US    = 25,
  parameter int PROG_US    = 200,
  parameter int DUMMY_US   = 5,
  parameter int ERASE_US   = 2000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ce_n,
  input  logic       cle,
  input  logic       ale,
  input  logic       we_n,
  input  logic       re_n,
  input  logic       wp_n,
  input  logic [7:0] din,
  output logic [7:0] dout,
  output logic       dout_en,
  output logic       busy
);
  localparam int PAGES      = PPB * BLOCKS;
  localparam int PAGE_BYTES = PAGE_MAIN + PAGE_SPARE;
  localparam int PAGE_W     = $clog2(PAGES);
  localparam int COL_W      = $clog2(PAGE_BYTES);
  localparam int BLK_W      = $clog2(BLOCKS);
  localparam int BLK_SHIFT  = $clog2(PPB);
  localparam logic [7:0] PB8   = 8'(PAGE_BYTES);
  localparam logic [7:0] MAIN8 = 8'(PAGE_MAIN);

  logic rst_s0, rst_n_s;
  logic cmd_stb, addr_stb, data_stb, rd_adv;
  mode_e mode_q, mode_d;
  logic [1:0] acnt_q, acnt_d;
  logic [7:0] col_q, col_d;
  logic [15:0] row_q, row_d;
  logic [PAGE_BYTES-1:0][7:0] buf_q, buf_d;
  logic tm_q, tm_d, ts_q, ts_d, fail_q, fail_d;
  logic busy_start, busy_clr, prog_req, erase_req, limit_ok, prog_ok;
  busy_kind_e busy_kind;
  logic [PAGE_W-1:0] page_idx;
  logic [COL_W-1:0] col_idx;
  logic [7:0] rd_byte, status_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {rst_n_s, rst_s0} <= 2'b00;
    else        {rst_n_s, rst_s0} <= {rst_s0, 1'b1};
  end

  nand_bus_decode u_dec (
    .clk(clk), .rst_n(rst_n_s), .ce_n(ce_n), .cle(cle), .ale(ale),
    .we_n(we_n), .re_n(re_n), .cmd_stb(cmd_stb), .addr_stb(addr_stb),
    .data_stb(data_stb), .rd_adv(rd_adv)
  );

  nand_busy_timer #(
    .CYC_PER_US(CYC_PER_US), .READ_US(READ_US), .PROG_US(PROG_US),
    .DUMMY_US(DUMMY_US), .ERASE_US(ERASE_US)
  ) u_timer (
    .clk(clk), .rst_n(rst_n_s), .start(busy_start), .kind(busy_kind),
    .clear(busy_clr), .busy(busy)
  );

  assign page_idx = row_q[PAGE_W-1:0];
  assign col_idx  = col_q[COL_W-1:0];
  assign prog_ok  = wp_n & limit_ok;

  nand_page_store #(
    .PAGE_MAIN(PAGE_MAIN), .PAGE_SPARE(PAGE_SPARE), .PPB(PPB), .BLOCKS(BLOCKS)
  ) u_store (
    .clk(clk), .rst_n(rst_n_s), .prog_page(page_idx), .prog_buf(buf_q),
    .prog_main(tm_q), .prog_spare(ts_q), .prog_en(prog_req & prog_ok),
    .limit_ok(limit_ok), .erase_en(erase_req),
    .erase_blk(page_idx[PAGE_W-1:BLK_SHIFT]), .rd_page(page_idx),
    .rd_col(col_idx), .rd_byte(rd_byte)
  );

  always_comb begin
    mode_d = mode_q; acnt_d = acnt_q; col_d = col_q; row_d = row_q;
    buf_d = buf_q; tm_d = tm_q; ts_d = ts_q; fail_d = fail_q;
    busy_start = 1'b0; busy_kind = BK_READ; busy_clr = 1'b0;
    prog_req = 1'b0; erase_req = 1'b0;
    if (cmd_stb && din == CMD_RESET) begin
      busy_clr = 1'b1;
      mode_d   = M_IDLE;
    end else if (!busy) begin
      if (cmd_stb) begin
        mode_d = M_IDLE;
        acnt_d = 2'd0;
        unique case (din)
          CMD_READ:   mode_d = M_RD_ADDR;
          CMD_PROG: begin
            mode_d = M_PG_ADDR;
            buf_d  = '1;
            tm_d   = 1'b0;
            ts_d   = 1'b0;
          end
          CMD_PROG_GO, CMD_PROG_PLANE: begin
            if (mode_q == M_PG_DATA) begin
              prog_req   = 1'b1;
              fail_d     = ~prog_ok;
              busy_start = 1'b1;
              busy_kind  = (din == CMD_PROG_GO) ? BK_PROG : BK_DUMMY;
            end
          end
          CMD_ERASE:  mode_d = M_ER_ADDR;
          CMD_ERASE_GO: begin
            if (mode_q == M_ER_WAIT) begin
              erase_req  = wp_n;
              fail_d     = ~wp_n;
              busy_start = 1'b1;
              busy_kind  = BK_ERASE;
            end
          end
          CMD_STATUS: mode_d = M_STATUS;
          default:    mode_d = M_IDLE;
        endcase
      end else if (addr_stb && (mode_q == M_RD_ADDR || mode_q == M_PG_ADDR ||
                                mode_q == M_ER_ADDR)) begin
        acnt_d = acnt_q + 2'd1;
        unique case (acnt_q)
          2'd0:    col_d = din;
          2'd1:    row_d[7:0] = din;
          2'd2:    row_d[15:8] = din;
          default: begin
            if (mode_q == M_RD_ADDR) begin
              mode_d     = M_RD_OUT;
              busy_start = 1'b1;
              busy_kind  = BK_READ;
            end else if (mode_q == M_PG_ADDR) begin
              mode_d = M_PG_DATA;
            end else begin
              mode_d = M_ER_WAIT;
            end
          end
        endcase
      end else if (data_stb && mode_q == M_PG_DATA) begin
        if (col_q < PB8) begin
          buf_d[col_idx] = din;
          if (col_q < MAIN8) tm_d = 1'b1;
          else               ts_d = 1'b1;
          col_d = col_q + 8'd1;
        end
      end else if (rd_adv && mode_q == M_RD_OUT) begin
        if (col_q < PB8) col_d = col_q + 8'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      mode_q <= M_IDLE; acnt_q <= 2'd0; col_q <= 8'd0; row_q <= 16'd0;
      buf_q <= '1; tm_q <= 1'b0; ts_q <= 1'b0; fail_q <= 1'b0;
    end else begin
      mode_q <= mode_d; acnt_q <= acnt_d; col_q <= col_d; row_q <= row_d;
      buf_q <= buf_d; tm_q <= tm_d; ts_q <= ts_d; fail_q <= fail_d;
    end
  end

  always_comb begin
    status_byte = {wp_n, ~busy, 5'd0, fail_q};
    dout        = 8'h00;
    if (mode_q == M_STATUS)    dout = status_byte;
    else if (mode_q == M_RD_OUT) dout = (col_q < PB8) ? rd_byte : 8'hFF;
    dout_en = ~ce_n & ~re_n & ~busy & ((mode_q == M_STATUS) | (mode_q == M_RD_OUT));
  end
endmodule

// File: rtl/nand_emu_chk.sv
module nand_emu_chk #(
  parameter int MAX_BUSY = 2000
) (
  input logic       clk,
  input logic       rst_n,
  input logic       ce_n,
  input logic       re_n,
  input logic       busy,
  input logic       dout_en,
  input logic [7:0] dout,
  input logic       cmd_stb,
  input logic       addr_stb,
  input logic [2:0] mode
);
  localparam int RUN_W = $clog2(MAX_BUSY + 2);
  localparam logic [2:0] MODE_STATUS = 3'd7;
  logic [RUN_W-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               run_q <= '0;
    else if (!busy)           run_q <= '0;
    else if (run_q != '1)     run_q <= run_q + 1'b1;
  end

  // R9
  busy_no_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !dout_en);

  // R12
  out_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dout_en |-> (!ce_n && !re_n));

  // R8
  busy_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cmd_stb || addr_stb));

  // R8
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= RUN_W'(MAX_BUSY));

  // R9
  busy_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !cmd_stb) |=> $stable(mode));

  // R10
  status_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_en && mode == MODE_STATUS) |-> dout[6]);
endmodule

bind nand_emu nand_emu_chk #(.MAX_BUSY(ERASE_US * CYC_PER_US)) u_chk (
  .clk(clk), .rst_n(rst_n_s), .ce_n(ce_n), .re_n(re_n), .busy(busy),
  .dout_en(dout_en), .dout(dout), .cmd_stb(cmd_stb), .addr_stb(addr_stb),
  .mode(mode_q)
);

// File: tb/test_nand_emu.sv
module test_nand_emu;
  logic clk = 1'b0;
  logic rst_n, ce_n, cle, ale, we_n, re_n, wp_n;
  logic [7:0] din, dout;
  logic dout_en, busy;
  int nchk = 0;
  int nfail = 0;

  always #4 clk = ~clk;

  nand_emu i_nand_emu (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cle(cle), .ale(ale),
    .we_n(we_n), .re_n(re_n), .wp_n(wp_n), .din(din), .dout(dout),
    .dout_en(dout_en), .busy(busy)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic c, input logic a, input logic [7:0] b);
    @(negedge clk); cle = c; ale = a; din = b; we_n = 1'b0;
    @(negedge clk); we_n = 1'b1;
    @(negedge clk); cle = 1'b0; ale = 1'b0;
  endtask

  task automatic addr4(input logic [7:0] col, input logic [7:0] row);
    wr(0, 1, col); wr(0, 1, row); wr(0, 1, 8'h00); wr(0, 1, 8'h5A);
  endtask

  task automatic wait_ready(output int n);
    n = 0;
    while (busy && n < 5000) begin n++; @(negedge clk); end
  endtask

  task automatic rd(output logic [7:0] b, output logic en);
    @(negedge clk); re_n = 1'b0;
    @(negedge clk); b = dout; en = dout_en; re_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic start_read(input logic [7:0] row, input logic [7:0] col, output int n);
    wr(1, 0, 8'h00); addr4(col, row); wait_ready(n);
  endtask

  task automatic expect_byte(input string tag, input logic [7:0] exp);
    logic [7:0] b; logic en;
    rd(b, en);
    chk({tag, " en"}, int'(en), 1);
    chk(tag, int'(b), int'(exp));
  endtask

  task automatic prog1(input logic [7:0] row, input logic [7:0] col,
                       input logic [7:0] d, input logic [7:0] cfm, output int n);
    wr(1, 0, 8'h80); addr4(col, row); wr(0, 0, d); wr(1, 0, cfm); wait_ready(n);
  endtask

  task automatic expect_status(input string tag, input logic [7:0] exp);
    wr(1, 0, 8'h70);
    expect_byte(tag, exp);
  endtask

  task automatic t_reset;
    int n;
    chk("R11 busy", int'(busy), 0);
    chk("R11 dout_en", int'(dout_en), 0);
    start_read(8'd0, 8'd0, n);
    expect_byte("R11 erased byte", 8'hFF);
  endtask

  task automatic t_program_read;
    int n;
    wr(1, 0, 8'h80); addr4(8'd0, 8'd1); wr(0, 0, 8'hA5); wr(0, 0, 8'h3C);
    wr(1, 0, 8'h10); wait_ready(n);
    chk("R8 program busy", n, 200);
    expect_status("R10 status pass", 8'hC0);
    start_read(8'd1, 8'd0, n);
    chk("R8 read busy", n, 25);
    expect_byte("R2 R3 col0", 8'hA5);
    expect_byte("R12 col1", 8'h3C);
    expect_byte("R3 unwritten col2", 8'hFF);
  endtask

  task automatic t_main_limit;
    int n;
    prog1(8'd1, 8'd0, 8'h0F, 8'h10, n);
    expect_status("R4 status fail", 8'hC1);
    start_read(8'd1, 8'd0, n);
    expect_byte("R4 unchanged", 8'hA5);
  endtask

  task automatic t_spare_limit;
    int n;
    prog1(8'd1, 8'd8, 8'hF0, 8'h10, n);
    expect_status("R5 first spare", 8'hC0);
    prog1(8'd1, 8'd8, 8'h3C, 8'h10, n);
    expect_status("R5 second spare", 8'hC0);
    prog1(8'd1, 8'd9, 8'h00, 8'h10, n);
    expect_status("R5 third spare rejected", 8'hC1);
    start_read(8'd1, 8'd8, n);
    expect_byte("R3 AND in spare", 8'h30);
    expect_byte("R5 col9 unchanged", 8'hFF);
    expect_byte("R12 past end", 8'hFF);
  endtask

  task automatic t_write_protect;
    int n;
    wp_n = 1'b0;
    expect_status("R10 wp bit", 8'h41);
    prog1(8'd0, 8'd1, 8'h00, 8'h10, n);
    wr(1, 0, 8'h60); addr4(8'd0, 8'd1); wr(1, 0, 8'hD0); wait_ready(n);
    wp_n = 1'b1;
    expect_status("R6 refused", 8'hC1);
    start_read(8'd1, 8'd0, n);
    expect_byte("R6 block kept", 8'hA5);
    start_read(8'd0, 8'd1, n);
    expect_byte("R6 page0 kept", 8'hFF);
  endtask

  task automatic t_erase;
    int n;
    prog1(8'd2, 8'd0, 8'h77, 8'h10, n);
    wr(1, 0, 8'h60); addr4(8'd0, 8'd1); wr(1, 0, 8'hD0); wait_ready(n);
    chk("R8 erase busy", n, 2000);
    expect_status("R7 erase pass", 8'hC0);
    start_read(8'd1, 8'd0, n);
    expect_byte("R7 erased", 8'hFF);
    start_read(8'd2, 8'd0, n);
    expect_byte("R7 other block", 8'h77);
    prog1(8'd1, 8'd0, 8'h12, 8'h10, n);
    expect_status("R7 counts cleared", 8'hC0);
    start_read(8'd1, 8'd0, n);
    expect_byte("R7 reprogrammed", 8'h12);
  endtask

  task automatic t_busy_ignore;
    int n;
    wr(1, 0, 8'hFF);
    wr(1, 0, 8'h80); addr4(8'd0, 8'd3); wr(0, 0, 8'h55); wr(1, 0, 8'h10);
    wr(1, 0, 8'h70);
    wait_ready(n);
    @(negedge clk); re_n = 1'b0;
    @(negedge clk); chk("R9 command ignored while busy", int'(dout_en), 0);
    re_n = 1'b1;
    wr(1, 0, 8'h80); addr4(8'd0, 8'd0); wr(0, 0, 8'h99); wr(1, 0, 8'h10);
    chk("R9 busy before reset", int'(busy), 1);
    wr(1, 0, 8'hFF);
    chk("R9 reset ends busy", int'(busy), 0);
    start_read(8'd0, 8'd0, n);
    expect_byte("R9 data committed", 8'h99);
  endtask

  task automatic t_dummy;
    int n;
    prog1(8'd3, 8'd8, 8'hAB, 8'h11, n);
    chk("R8 dummy busy", n, 5);
    start_read(8'd3, 8'd8, n);
    expect_byte("R8 plane program stored", 8'hAB);
  endtask

  task automatic t_ce_high;
    wr(1, 0, 8'hFF);
    ce_n = 1'b1;
    wr(1, 0, 8'h70);
    ce_n = 1'b0;
    @(negedge clk); re_n = 1'b0;
    @(negedge clk); chk("R1 strobe with ce_n high", int'(dout_en), 0);
    re_n = 1'b1;
  endtask

  task automatic finish_up;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_up();
  end

  initial begin
    rst_n = 1'b0; ce_n = 1'b0; cle = 1'b0; ale = 1'b0;
    we_n = 1'b1; re_n = 1'b1; wp_n = 1'b1; din = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_program_read();
    t_main_limit();
    t_spare_limit();
    t_write_protect();
    t_erase();
    t_busy_ignore();
    t_dummy();
    t_ce_high();
    finish_up();
  end
endmodule